// File: doc/BRIEF.md
# Serial-Port FIFO Status and Interrupt Unit

This block supplies the flag, interrupt and DMA request logic that sits beside the transmit and receive queues of a serial port. The queue storage and the shift engine are outside it. It sees the two fill levels, a strobe for each frame written into the receive queue, a strobe for each entry popped from it, and a busy indication from the shift engine. From these it builds a five-bit status word and four interrupt sources. Two of the sources are levels that follow the queue fill. Two are sticky events: an overrun when a frame arrives at a full receive queue, and a timeout when received data waits unread for too long.

A small register port reads and writes the interrupt mask, reads the raw and masked interrupt words, takes write-one-to-clear commands for the sticky events, and holds the two DMA enables. The masked sources are ORed into one interrupt line. The receive DMA request follows data being present. The transmit DMA request follows the transmit queue having room.

Top module: `sfs_status_unit`

## Requirements
- R1: The status word has bit0 = transmit queue empty, bit1 = transmit queue not full, bit2 = receive queue not empty, bit3 = receive queue full, and bit4 = engine busy or transmit queue not empty.
- R2: Interrupt bit order in every interrupt word is bit0 overrun, bit1 receive timeout, bit2 receive half full, bit3 transmit half empty. Bit2 is a level that is high while the receive level is at least DEPTH/2. Bit3 is a level that is high while the transmit level is at most DEPTH/2.
- R3: A receive write strobe that arrives while the receive level equals DEPTH sets the overrun bit on the next clock. The bit then stays set until it is cleared.
- R4: While the receive queue holds data and sees no strobe, the timeout bit sets on the clock edge that ends TMO_SCLK*SCLK_DIV idle cycles, and stays set until it is cleared. The timeout fires once per idle stretch.
- R5: Any receive write or pop strobe, or an empty receive queue, restarts the timeout count from zero.
- R6: Writing the clear register (address 3) with bit0 or bit1 set clears overrun or timeout on the next clock. A set in the same cycle wins over the clear. Clear bits 2 and 3 have no effect on the level sources.
- R7: The masked word is raw AND mask (address 0, bits 3:0). The interrupt line is the OR of the masked word.
- R8: The DMA control register (address 4) bit0 enables the receive request, which is high while the receive queue is not empty. Bit1 enables the transmit request, which is high while the transmit queue is not full.
- R9: Reads return the mask at address 0, raw at 1, masked at 2, DMA control at 4 and status at 5. Address 3 and unmapped addresses read zero.
- R10: After reset the mask, the DMA enables and both sticky bits are zero, so the interrupt line and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | LW | Transmit queue fill, 0..DEPTH |
| rx_level | input | LW | Receive queue fill, 0..DEPTH |
| rx_push | input | 1 | A received frame is written this cycle |
| rx_pop | input | 1 | An entry is read from the receive queue this cycle |
| engine_busy | input | 1 | Shift engine is moving a frame |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| status | output | 5 | Status word |
| irq_raw | output | 4 | Raw interrupt word |
| irq_masked | output | 4 | Masked interrupt word |
| irq | output | 1 | Combined interrupt line |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume that both fill levels stay within 0..DEPTH, and one property checks this on the inputs. They also assume the strobes agree with the levels, so that a pop never comes from an empty queue. The stimulus sets levels only inside that range and raises a strobe only in a cycle where it matches the level it drives. The timeout window is measured with the block's own counter, so no property reaches back a parameter-sized number of cycles. The bench shortens the window to keep the run brief.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam int IRQ_N = 4;
  localparam int IRQ_OVR = 0;
  localparam int IRQ_TMO = 1;
  localparam int IRQ_RXH = 2;
  localparam int IRQ_TXH = 3;

  localparam int ST_W = 5;

  typedef enum logic [2:0] {
    RA_MASK = 3'd0,
    RA_RAW  = 3'd1,
    RA_MIS  = 3'd2,
    RA_CLR  = 3'd3,
    RA_DMA  = 3'd4,
    RA_STAT = 3'd5
  } reg_addr_e;

  // status word from fill levels
  function automatic logic [ST_W-1:0] status_word(int unsigned depth, int unsigned tx,
                                                  int unsigned rx, logic busy);
    logic [ST_W-1:0] s;
    s[0] = (tx == 0);
    s[1] = (tx < depth);
    s[2] = (rx != 0);
    s[3] = (rx == depth);
    s[4] = busy | (tx != 0);
    return s;
  endfunction

  function automatic logic rx_half(int unsigned depth, int unsigned rx);
    return rx >= depth / 2;
  endfunction

  function automatic logic tx_half(int unsigned depth, int unsigned tx);
    return tx <= depth / 2;
  endfunction

  function automatic int unsigned tmo_limit(int unsigned sclk_cycles, int unsigned div);
    return sclk_cycles * div;
  endfunction

endpackage

// File: rtl/sfs_level_decode.sv
module sfs_level_decode
  import sfs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0]   tx_level,
  input  logic [LW-1:0]   rx_level,
  input  logic            busy_in,
  output logic [ST_W-1:0] status_o,
  output logic            rx_half_o,
  output logic            tx_half_o,
  output logic            rx_full_o,
  output logic            rx_nonempty_o,
  output logic            tx_notfull_o
);

  always_comb begin
    status_o      = status_word(DEPTH, int'(tx_level), int'(rx_level), busy_in);
    rx_half_o     = rx_half(DEPTH, int'(rx_level));
    tx_half_o     = tx_half(DEPTH, int'(tx_level));
    rx_full_o     = status_o[3];
    rx_nonempty_o = status_o[2];
    tx_notfull_o  = status_o[1];
  end

endmodule

// File: rtl/sfs_rx_timeout.sv
module sfs_rx_timeout #(
  parameter int LIMIT = 128,
  parameter int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_nonempty,
  input  logic rx_push,
  input  logic rx_pop,
  output logic expire_o
);

  localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          restart;

  assign restart  = rx_push | rx_pop | ~rx_nonempty;
  assign expire_o = ~restart & (cnt_q == LIM_M1);

  // saturates at LIMIT so the event fires once per idle stretch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
  end

  // R5: any strobe restarts the count
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_pop) |=> (cnt_q == '0));

  // R4: expiry only with data waiting
  a_r4_expire_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> rx_nonempty);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_C);

  // R4: at most one expiry per stretch
  a_r4_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

endmodule

// File: rtl/sfs_irq_regs.sv
module sfs_irq_regs
  import sfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_set,
  input  logic             tmo_set,
  input  logic             rx_half,
  input  logic             tx_half,
  input  logic             rx_nonempty,
  input  logic             tx_notfull,
  input  logic [ST_W-1:0]  status_in,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [IRQ_N-1:0] raw_o,
  output logic [IRQ_N-1:0] mis_o,
  output logic             irq_o,
  output logic             dma_rx_o,
  output logic             dma_tx_o
);

  logic [IRQ_N-1:0] mask_q;
  logic [1:0]       dma_en_q;
  logic [1:0]       sticky_q;
  logic [1:0]       sticky_set;
  logic [1:0]       clr_hit;
  logic             wr_mask, wr_dma, wr_clr;
  logic             unused_wdata;

  assign wr_mask = reg_wr && (reg_addr == RA_MASK);
  assign wr_dma  = reg_wr && (reg_addr == RA_DMA);
  assign wr_clr  = reg_wr && (reg_addr == RA_CLR);
  assign clr_hit = wr_clr ? reg_wdata[1:0] : 2'b00;
  assign sticky_set = {tmo_set, ovr_set};
  assign unused_wdata = ^reg_wdata[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      dma_en_q <= '0;
    end else begin
      if (wr_mask) mask_q   <= reg_wdata[IRQ_N-1:0];
      if (wr_dma)  dma_en_q <= reg_wdata[1:0];
    end
  end

  // sticky sources: set has priority over clear
  for (genvar g = 0; g < 2; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q[g] <= 1'b0;
      else        sticky_q[g] <= sticky_set[g] | (sticky_q[g] & ~clr_hit[g]);
    end
  end

  assign raw_o[IRQ_OVR] = sticky_q[0];
  assign raw_o[IRQ_TMO] = sticky_q[1];
  assign raw_o[IRQ_RXH] = rx_half;
  assign raw_o[IRQ_TXH] = tx_half;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_mis
    assign mis_o[g] = raw_o[g] & mask_q[g];
  end

  assign irq_o    = |mis_o;
  assign dma_rx_o = dma_en_q[0] & rx_nonempty;
  assign dma_tx_o = dma_en_q[1] & tx_notfull;

  always_comb begin
    case (reg_addr)
      RA_MASK: reg_rdata = {4'b0, mask_q};
      RA_RAW:  reg_rdata = {4'b0, raw_o};
      RA_MIS:  reg_rdata = {4'b0, mis_o};
      RA_DMA:  reg_rdata = {6'b0, dma_en_q};
      RA_STAT: reg_rdata = {3'b0, status_in};
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r3_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> raw_o[IRQ_OVR]);

  a_r3_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o[IRQ_OVR] && !(wr_clr && reg_wdata[0])) |=> raw_o[IRQ_OVR]);

  a_r4_tmo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o[IRQ_TMO] && !(wr_clr && reg_wdata[1])) |=> raw_o[IRQ_TMO]);

  a_r6_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[0] && !ovr_set) |=> !raw_o[IRQ_OVR]);

  a_r6_tmo_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[1] && !tmo_set) |=> !raw_o[IRQ_TMO]);

  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0));

  a_r8_dma_rx_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_o |-> status_in[2]);

endmodule

// File: rtl/sfs_status_unit.sv
module sfs_status_unit
  import sfs_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TMO_SCLK   = 32,
  parameter int SCLK_DIV   = 4,
  parameter int LW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             engine_busy,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [ST_W-1:0]  status,
  output logic [IRQ_N-1:0] irq_raw,
  output logic [IRQ_N-1:0] irq_masked,
  output logic             irq,
  output logic             dma_rx_req,
  output logic             dma_tx_req
);

  localparam int TMO_LIMIT = tmo_limit(TMO_SCLK, SCLK_DIV);
  localparam logic [LW-1:0] DEPTH_C = LW'(FIFO_DEPTH);

  logic rx_half, tx_half, rx_full, rx_nonempty, tx_notfull;
  logic ovr_event, tmo_event;

  sfs_level_decode #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_decode (
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .busy_in       (engine_busy),
    .status_o      (status),
    .rx_half_o     (rx_half),
    .tx_half_o     (tx_half),
    .rx_full_o     (rx_full),
    .rx_nonempty_o (rx_nonempty),
    .tx_notfull_o  (tx_notfull)
  );

  assign ovr_event = rx_push & rx_full;

  sfs_rx_timeout #(.LIMIT(TMO_LIMIT)) u_tmo (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_nonempty (rx_nonempty),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .expire_o    (tmo_event)
  );

  sfs_irq_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovr_set     (ovr_event),
    .tmo_set     (tmo_event),
    .rx_half     (rx_half),
    .tx_half     (tx_half),
    .rx_nonempty (rx_nonempty),
    .tx_notfull  (tx_notfull),
    .status_in   (status),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .raw_o       (irq_raw),
    .mis_o       (irq_masked),
    .irq_o       (irq),
    .dma_rx_o    (dma_rx_req),
    .dma_tx_o    (dma_tx_req)
  );

  // input assumption checked: levels within range (R1)
  a_r1_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= DEPTH_C) && (rx_level <= DEPTH_C));

  // R3: full queue plus arriving frame raises overrun
  a_r3_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == DEPTH_C) |=> irq_raw[IRQ_OVR]);

  // R8: transmit request only with room
  a_r8_dma_tx_room: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> (tx_level != DEPTH_C));

endmodule

// File: tb/sfs_status_unit_bench.sv
module sfs_status_unit_bench;

  localparam int DEPTH = 8;
  localparam int LW = 4;
  localparam int DIV = 2;
  localparam int LIMIT = 32 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic rx_push = 1'b0, rx_pop = 1'b0, engine_busy = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] status;
  logic [3:0] irq_raw, irq_masked;
  logic irq, dma_rx_req, dma_tx_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sfs_status_unit #(.FIFO_DEPTH(DEPTH), .TMO_SCLK(32), .SCLK_DIV(DIV)) u_sfs_status_unit (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_push(rx_push), .rx_pop(rx_pop), .engine_busy(engine_busy),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status(status), .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  // {tx[15:12], rx[11:8], busy[7], status[6:2], txhalf[1], rxhalf[0]}
  localparam logic [15:0] VEC [8] = '{
    {4'd0, 4'd0, 1'b0, 5'b00011, 2'b10},
    {4'd0, 4'd0, 1'b1, 5'b10011, 2'b10},
    {4'd8, 4'd8, 1'b0, 5'b11100, 2'b01},
    {4'd4, 4'd4, 1'b0, 5'b10110, 2'b11},
    {4'd5, 4'd3, 1'b0, 5'b10110, 2'b00},
    {4'd1, 4'd1, 1'b1, 5'b10110, 2'b10},
    {4'd7, 4'd7, 1'b0, 5'b10110, 2'b01},
    {4'd3, 4'd8, 1'b0, 5'b11110, 2'b11}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10: reset state
    check("R10 irq", irq, 0);
    check("R10 dma", {dma_rx_req, dma_tx_req}, 0);
    check("R10 sticky", irq_raw[1:0], 0);
    reg_read(3'd0, rd); check("R10 mask", rd, 0);
    reg_read(3'd4, rd); check("R10 dmactl", rd, 0);

    // R1/R2: level vectors
    for (int i = 0; i < 8; i++) begin
      tx_level = VEC[i][15:12];
      rx_level = VEC[i][11:8];
      engine_busy = VEC[i][7];
      tick();
      check("R1 status", status, VEC[i][6:2]);
      check("R2 half", irq_raw[3:2], VEC[i][1:0]);
    end
    rx_level = 0; tx_level = 0; engine_busy = 0;
    tick();

    // R7: masking and combined line
    reg_write(3'd0, 8'h08);
    check("R7 masked", irq_masked, 4'b1000);
    check("R7 irq", irq, 1);
    reg_write(3'd0, 8'h04);
    check("R7 masked off", irq_masked, 0);
    check("R7 irq off", irq, 0);

    // R3: overrun
    reg_write(3'd0, 8'h01);
    rx_level = 4'd8; rx_push = 1'b1;
    tick();
    rx_push = 1'b0;
    #1;
    check("R3 overrun set", irq_raw[0], 1);
    check("R7 irq on overrun", irq, 1);
    repeat (3) tick();
    check("R3 overrun sticky", irq_raw[0], 1);
    // R6: clear bit0
    reg_write(3'd3, 8'h01);
    check("R6 overrun cleared", irq_raw[0], 0);
    // R6: set wins over clear
    rx_push = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01; reg_wr = 1'b1;
    tick();
    rx_push = 1'b0; reg_wr = 1'b0;
    #1;
    check("R6 set beats clear", irq_raw[0], 1);
    reg_write(3'd3, 8'h01);
    // R3: push at non-full level
    rx_level = 4'd7; rx_push = 1'b1;
    tick();
    rx_push = 1'b0;
    #1;
    check("R3 no overrun below full", irq_raw[0], 0);

    // R6: clear bits for level sources have no effect
    rx_level = 4'd4; tx_level = 4'd2;
    reg_write(3'd3, 8'h0C);
    check("R6 levels unaffected", irq_raw[3:2], 2'b11);
    rx_level = 0; tx_level = 0;
    tick();

    // R4: timeout
    rx_push = 1'b1; rx_level = 4'd1;
    tick();
    rx_push = 1'b0;
    repeat (LIMIT - 1) tick();
    check("R4 no timeout early", irq_raw[1], 0);
    tick();
    check("R4 timeout set", irq_raw[1], 1);
    repeat (5) tick();
    check("R4 timeout sticky", irq_raw[1], 1);
    reg_write(3'd3, 8'h02);
    repeat (3) tick();
    check("R4 fires once", irq_raw[1], 0);

    // R5: pop restarts the count
    rx_push = 1'b1; rx_level = 4'd2;
    tick();
    rx_push = 1'b0;
    repeat (40) tick();
    rx_pop = 1'b1; rx_level = 4'd1;
    tick();
    rx_pop = 1'b0;
    repeat (LIMIT - 1) tick();
    check("R5 restart delays timeout", irq_raw[1], 0);
    tick();
    check("R5 timeout after restart", irq_raw[1], 1);
    reg_write(3'd3, 8'h02);
    rx_level = 0;
    tick();

    // R8: DMA requests
    reg_write(3'd4, 8'h03);
    tx_level = 4'd8; rx_level = 4'd0; #1;
    check("R8 dma idle", {dma_rx_req, dma_tx_req}, 2'b00);
    tx_level = 4'd2; rx_level = 4'd1; #1;
    check("R8 dma both", {dma_rx_req, dma_tx_req}, 2'b11);
    reg_write(3'd4, 8'h01);
    check("R8 dma rx only", {dma_rx_req, dma_tx_req}, 2'b10);

    // R9: read map
    reg_write(3'd0, 8'h0F);
    reg_read(3'd0, rd); check("R9 mask rd", rd, 8'h0F);
    reg_read(3'd1, rd); check("R9 raw rd", rd, {4'b0, irq_raw});
    reg_read(3'd2, rd); check("R9 mis rd", rd, {4'b0, irq_masked});
    reg_read(3'd3, rd); check("R9 clr rd", rd, 0);
    reg_read(3'd4, rd); check("R9 dma rd", rd, 8'h01);
    reg_read(3'd5, rd); check("R9 status rd", rd, 8'b0001_0110);
    reg_read(3'd7, rd); check("R9 unmapped rd", rd, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule